// File: doc/BRIEF.md
# Weight-Stationary 1-D Convolution Engine

This block computes a 'valid' 1-D convolution of a signed input row with a short signed filter. It uses a weight-stationary schedule. The outer loop steps through the filter taps. For each tap, one weight is fetched into a local register, and that weight is held while the inner loop sweeps every output position. Each output partial sum makes one read-modify-write round trip per tap through an on-block output buffer. The update is pipelined, so the engine completes one multiply-accumulate per clock. When consecutive updates hit the same output address, the pending result is forwarded.

Software loads the input row and the filter through two write ports and then pulses `start`. When `done` pulses, the results can be read back through a registered read port. Four saturating counters report the memory traffic of the last run: weight reads, input reads, output-buffer reads and output-buffer writes.

Top module: `wstat_conv1d`

## Requirements
- R1: With NIN inputs and NTAP taps, the engine produces NOUT = NIN - NTAP + 1 outputs. Each output is O[e] = sum over r of W[r]*I[e+r], using signed 8-bit operands and a signed 20-bit result. `rd_data` returns O[`rd_addr`] one clock after the address is presented.
- R2: If `start` is sampled high at clock edge 0 while idle, `busy` is high through edge NOUT*NTAP. `done` is high for exactly one cycle, after edge NOUT*NTAP+1, which is the edge that performs the final buffer write.
- R3: Each weight is read once per run, on the first output position of its tap. The weight-read count after edge k is floor((min(k, NOUT*NTAP) - 1)/NOUT) + 1, and it ends at NTAP.
- R4: Input reads and output-buffer reads each rise by one on every MAC edge and end at NOUT*NTAP. Output-buffer writes follow one edge later and also end at NOUT*NTAP. Every write targets an address in 0..NOUT-1.
- R5: The output buffer and all counters are cleared on an accepted `start`, so the results of a run do not depend on any earlier run.
- R6: When NOUT = 1, every MAC hits the same address in back-to-back cycles. The result still equals the full sum, because the pending update is forwarded to the next read.
- R7: Each counter saturates at 2^CNTW - 1 and holds that value until the next accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored. Counters, timing and results continue as if there had been no pulse.
- R9: After reset, `busy` and `done` are low and all four counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_we | input | 1 | Input-row write enable |
| in_waddr | input | IAW | Input-row write index |
| in_wdata | input | DW | Signed input activation |
| wt_we | input | 1 | Filter write enable |
| wt_waddr | input | TAW | Filter tap index |
| wt_wdata | input | DW | Signed filter weight |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final write |
| rd_addr | input | OAW | Output read index |
| rd_data | output | ACCW | Signed output, one cycle after rd_addr |
| cnt_wt_rd | output | CNTW | Weight reads in the last run |
| cnt_in_rd | output | CNTW | Input reads in the last run |
| cnt_out_rd | output | CNTW | Output-buffer reads in the last run |
| cnt_out_wr | output | CNTW | Output-buffer writes in the last run |

## Verification
The counters act as a cycle-exact record of the schedule. A loop index that advances wrongly, or a weight that is fetched at the wrong time, shows up within one clock as a mismatch against the bench's per-edge model of the four counts. A wrong value in the held weight register, or a missed forward, leaves the counts correct but corrupts the partial sums. That error only appears at readout, so every output of every run is compared against the expected result. A small second instance with a single output position forces the forwarding path on every cycle and drives the counters into saturation.

// File: rtl/wstat_conv1d.sv
module wstat_conv1d #(
  parameter int NIN  = 16,
  parameter int NTAP = 4,
  parameter int DW   = 8,
  parameter int ACCW = 20,
  parameter int CNTW = 16,
  localparam int NOUT = NIN - NTAP + 1,
  localparam int IAW  = $clog2(NIN),
  localparam int TAW  = $clog2(NTAP),
  localparam int OAW  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_we,
  input  logic [IAW-1:0]         in_waddr,
  input  logic signed [DW-1:0]   in_wdata,
  input  logic                   wt_we,
  input  logic [TAW-1:0]         wt_waddr,
  input  logic signed [DW-1:0]   wt_wdata,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  input  logic [OAW-1:0]         rd_addr,
  output logic signed [ACCW-1:0] rd_data,
  output logic [CNTW-1:0]        cnt_wt_rd,
  output logic [CNTW-1:0]        cnt_in_rd,
  output logic [CNTW-1:0]        cnt_out_rd,
  output logic [CNTW-1:0]        cnt_out_wr
);

  localparam logic [CNTW-1:0] CMAX = '1;

  logic signed [DW-1:0]   imem [NIN];
  logic signed [DW-1:0]   wmem [NTAP];
  logic signed [ACCW-1:0] obuf [NOUT];

  logic                   run, pv, plast;
  logic [OAW-1:0]         e, pa;
  logic [TAW-1:0]         r;
  logic signed [DW-1:0]   wreg;
  logic signed [ACCW-1:0] ps;

  always_ff @(posedge clk) begin
    if (in_we) imem[in_waddr] <= in_wdata;
    if (wt_we) wmem[wt_waddr] <= wt_wdata;
  end

  wire                   first_e = (e == '0);
  wire                   last_e  = (e == OAW'(NOUT - 1));
  wire                   last    = last_e && (r == TAW'(NTAP - 1));
  wire                   go      = start && !run && !pv;
  wire [IAW-1:0]         iidx    = IAW'(e) + IAW'(r);
  wire signed [DW-1:0]   wcur    = first_e ? wmem[r] : wreg;
  wire signed [2*DW-1:0] prod    = wcur * imem[iidx];
  wire signed [ACCW-1:0] old     = (r == '0) ? '0 : (pv && pa == e) ? ps : obuf[e];
  wire signed [ACCW-1:0] sum     = old + ACCW'(prod);

  assign busy = run || pv;

  function automatic logic [CNTW-1:0] sat_inc(input logic [CNTW-1:0] c);
    return (c == CMAX) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; e <= '0; r <= '0; wreg <= '0;
      pv <= 1'b0; pa <= '0; ps <= '0; plast <= 1'b0; done <= 1'b0;
      cnt_wt_rd <= '0; cnt_in_rd <= '0; cnt_out_rd <= '0; cnt_out_wr <= '0;
    end else begin
      pv    <= run;
      pa    <= e;
      ps    <= sum;
      plast <= last;
      done  <= pv && plast;
      if (run) wreg <= wcur;
      if (go) begin
        run <= 1'b1; e <= '0; r <= '0;
        cnt_wt_rd <= '0; cnt_in_rd <= '0; cnt_out_rd <= '0; cnt_out_wr <= '0;
      end else begin
        if (run) begin
          cnt_in_rd  <= sat_inc(cnt_in_rd);
          cnt_out_rd <= sat_inc(cnt_out_rd);
          if (first_e) cnt_wt_rd <= sat_inc(cnt_wt_rd);
          if (last) run <= 1'b0;
          if (last_e) begin
            e <= '0;
            r <= r + 1'b1;
          end else begin
            e <= e + 1'b1;
          end
        end
        if (pv) cnt_out_wr <= sat_inc(cnt_out_wr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (go) begin
      for (int i = 0; i < NOUT; i++) obuf[i] <= '0;
    end else if (pv) begin
      obuf[pa] <= ps;
    end
    rd_data <= obuf[rd_addr];
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(pv));
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (pa <= OAW'(NOUT - 1)));
  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_out_rd == CMAX && !start) |=> cnt_out_rd == CMAX);
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cnt_wt_rd) && $stable(cnt_out_wr));

endmodule

// File: tb/wstat_conv1d_tb.sv
module wstat_conv1d_tb;
  localparam int NIN = 16, NTAP = 4, NOUT = NIN - NTAP + 1, ER = NOUT * NTAP;
  localparam int SN = 8, ST = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, fails = 0;

  logic in_we = 0, wt_we = 0, start = 0;
  logic [3:0] in_waddr = 0, rd_addr = 0;
  logic [1:0] wt_waddr = 0;
  logic signed [7:0] in_wdata = 0, wt_wdata = 0;
  logic busy, done;
  logic signed [19:0] rd_data;
  logic [15:0] c_wt, c_in, c_ord, c_owr;

  wstat_conv1d u_dut (.clk(clk), .rst_n(rst_n), .in_we(in_we), .in_waddr(in_waddr),
    .in_wdata(in_wdata), .wt_we(wt_we), .wt_waddr(wt_waddr), .wt_wdata(wt_wdata),
    .start(start), .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_wt_rd(c_wt), .cnt_in_rd(c_in), .cnt_out_rd(c_ord), .cnt_out_wr(c_owr));

  logic s_in_we = 0, s_wt_we = 0, s_start = 0;
  logic [2:0] s_in_waddr = 0, s_wt_waddr = 0;
  logic [0:0] s_rd_addr = 0;
  logic signed [7:0] s_in_wdata = 0, s_wt_wdata = 0;
  logic s_busy, s_done;
  logic signed [19:0] s_rd_data;
  logic [2:0] s_wt, s_in, s_ord, s_owr;

  wstat_conv1d #(.NIN(SN), .NTAP(ST), .CNTW(3)) u_dut_sm (.clk(clk), .rst_n(rst_n),
    .in_we(s_in_we), .in_waddr(s_in_waddr), .in_wdata(s_in_wdata), .wt_we(s_wt_we),
    .wt_waddr(s_wt_waddr), .wt_wdata(s_wt_wdata), .start(s_start), .busy(s_busy),
    .done(s_done), .rd_addr(s_rd_addr), .rd_data(s_rd_data), .cnt_wt_rd(s_wt),
    .cnt_in_rd(s_in), .cnt_out_rd(s_ord), .cnt_out_wr(s_owr));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_main(input int pat);
    int iv[NIN];
    int wv[NTAP];
    int ex[NOUT];
    int m_wt, m_rd, m_wr, dmax;
    for (int i = 0; i < NIN; i++)
      iv[i] = (pat == 0) ? (i * 7 % 23) - 11 : (pat == 1) ? -128 : ((i % 2) ? -128 : 127);
    for (int t = 0; t < NTAP; t++)
      wv[t] = (pat == 0) ? 3 - 2 * t : (pat == 1) ? -128 : ((t == 0) ? 127 : (t == 1) ? -128 : (t == 2) ? 1 : -1);
    for (int o = 0; o < NOUT; o++) begin
      ex[o] = 0;
      for (int t = 0; t < NTAP; t++) ex[o] += wv[t] * iv[o + t];
    end
    for (int i = 0; i < NIN; i++) begin
      @(negedge clk);
      in_we = 1; in_waddr = 4'(i); in_wdata = 8'(iv[i]);
      wt_we = (i < NTAP); wt_waddr = 2'(i); wt_wdata = 8'(wv[i % NTAP]);
    end
    @(negedge clk); in_we = 0; wt_we = 0; start = 1;
    @(posedge clk);
    @(negedge clk); start = 0;
    check(busy == 1, "R2 busy after start", busy, 1);
    m_wt = 0; m_rd = 0; m_wr = 0; dmax = 0;
    for (int k = 1; k <= ER + 2; k++) begin
      @(posedge clk);
      if (k <= ER) begin
        if (m_rd % NOUT == 0) m_wt++;
        m_rd++;
      end
      if (k >= 2 && k <= ER + 1) m_wr++;
      @(negedge clk);
      start = (pat == 2 && k == 5);
      check(c_wt == 16'(m_wt), "R3 weight reads", c_wt, m_wt);
      check(c_in == 16'(m_rd) && c_ord == 16'(m_rd), "R4 input/output reads", c_ord, m_rd);
      check(c_owr == 16'(m_wr), "R4 output writes", c_owr, m_wr);
      check(done == (k == ER + 1), "R2 done timing", done, k == ER + 1);
      check(busy == (k <= ER), "R2/R8 busy window", busy, k <= ER);
    end
    start = 0;
    check(c_wt == 16'(NTAP), "R3 final weight reads", c_wt, NTAP);
    for (int o = 0; o < NOUT; o++) begin
      @(negedge clk); rd_addr = 4'(o);
      @(posedge clk);
      @(negedge clk);
      check(rd_data == 20'(ex[o]), $sformatf("R1/R5/R8 pattern %0d output %0d", pat, o), rd_data, ex[o]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ex1;
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R9 reset flags", busy, 0);
    check(c_wt == 0 && c_in == 0 && c_ord == 0 && c_owr == 0, "R9 reset counters", c_ord, 0);
    rst_n = 1;
    @(negedge clk);
    run_main(0);
    run_main(1);
    run_main(2);
    run_main(0);
    ex1 = 0;
    for (int i = 0; i < SN; i++) begin
      @(negedge clk);
      s_in_we = 1; s_in_waddr = 3'(i); s_in_wdata = 8'(i * 9 - 30);
      s_wt_we = 1; s_wt_waddr = 3'(i); s_wt_wdata = 8'(5 - 3 * i);
      ex1 += (i * 9 - 30) * (5 - 3 * i);
    end
    @(negedge clk); s_in_we = 0; s_wt_we = 0; s_start = 1;
    @(negedge clk); s_start = 0;
    for (int k = 0; k < 40 && !s_done; k++) @(negedge clk);
    check(s_done == 1, "R2 small done", s_done, 1);
    check(s_wt == 3'd7 && s_in == 3'd7, "R7 saturated reads", s_wt, 7);
    check(s_ord == 3'd7 && s_owr == 3'd7, "R7 saturated buffer traffic", s_owr, 7);
    @(negedge clk); s_rd_addr = 0;
    @(posedge clk);
    @(negedge clk);
    check(s_rd_data == 20'(ex1), "R6 forwarded single output", s_rd_data, ex1);
    repeat (3) @(negedge clk);
    check(s_ord == 3'd7, "R7 hold after run", s_ord, 7);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule